// File: doc/BRIEF.md
# Ring doorbell and pointer unit

This block is the per-queue pointer keeper of a scatter-gather copy engine. It holds two rings side by side: a receive ring, which describes where data lands, and a transmit ring, which describes where data is read from. For each ring it keeps four indices: the tail that software extends with a doorbell, the fetch index of the executor, the completion index that software retires with an acknowledge, and a 2-bit phase for the tail and for the completion index. From these it derives the free-slot count and the count of descriptors still waiting for the executor.

Software reaches the block over a plain write/read register bus that carries a privilege bit. The ring base and completion base registers and the doorbell are write-protected: only privileged writes reach them, while everyone may read them. The doorbell adds a count to the tail. The acknowledge is a compare-and-advance on the completion index. Both are checked against ring capacity, batch size and receive-before-transmit order. A rejected access is reported in the same cycle and recorded in a sticky status register. The executor receives one pending count per ring and returns one fetch pulse for each descriptor it takes.

Top module: `ringdb_unit`

## Requirements
- R1: After reset every index, phase, pending count, base register and status bit of both rings reads zero, and the free count reads DEPTH-GUARD.
- R2: An accepted doorbell write of N adds N to the tail modulo DEPTH and adds N to pending. When the tail wraps past DEPTH-1 its phase becomes (phase+1)&3. A doorbell of 0 is accepted and changes nothing.
- R3: A doorbell write of N is rejected when N exceeds the free count or exceeds MAX_BATCH. The tail is unchanged, bus_fail is high in the cycle of the write, and status bit0 is set.
- R4: A transmit-ring doorbell of N is rejected (bus_fail, status bit2, tail unchanged) when N exceeds the number of descriptors doorbelled on the receive ring minus those doorbelled on the transmit ring.
- R5: The free count equals DEPTH - GUARD - ((tail - completion index) mod DEPTH).
- R6: A fetch pulse advances the fetch index by one and lowers pending by one. It is ignored while pending is zero.
- R7: A write to offset 0x34 carries the expected index in bits [15:0] and the count in bits [31:16]. It is accepted only when the expected index equals the completion index and the count does not exceed the descriptors fetched but not yet acknowledged. It then advances the completion index modulo DEPTH, and the completion phase steps on wrap. Otherwise bus_fail is high, status bit1 is set and nothing changes.
- R8: A transmit-ring acknowledge of count C is rejected (bus_fail, status bit2) when C exceeds the receive-ring acknowledged total minus the transmit-ring acknowledged total.
- R9: Unprivileged writes to offsets 0x00, 0x04, 0x08, 0x0C (ring base low/high, completion base low/high) and 0x38 (doorbell) change nothing, raise bus_fail and set status bit3. Privileged writes to the base offsets store 32 bits that read back unchanged.
- R10: Offset 0x20 is the status register {bit3 blocked, bit2 order, bit1 acknowledge, bit0 overflow}. A write to it from any privilege level clears the bits set in the write data.
- R11: Address bit 8 selects the ring (0 receive, 1 transmit). Reads: 0x10 tail as {phase in [17:16], index in [15:0]}, 0x14 fetch index, 0x18 free count, 0x1C pending, 0x34 completion index in the same format as the tail, 0x38 reads zero, and unmapped offsets read zero. Writes to read-only offsets have no effect and no fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 9 | Bit 8 ring select, bits 7:0 register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| bus_fail | output | 1 | The current write is blocked or rejected |
| rx_fetch | input | 1 | Executor took one receive descriptor |
| tx_fetch | input | 1 | Executor took one transmit descriptor |
| rx_pending | output | $clog2(DEPTH)+1 | Receive descriptors doorbelled but not fetched |
| tx_pending | output | $clog2(DEPTH)+1 | Transmit descriptors doorbelled but not fetched |

## Verification
The bench drives the ring to exactly zero free slots and then asks for one more. A design that forgets the guard gap, or compares with the wrong inequality, would accept that doorbell and let the tail run onto unacknowledged slots. It rings the transmit ring ahead of the receive ring and acknowledges transmit before receive; an order-blind design would accept both. It sends compare-and-advance writes with a stale expected index, and with a count larger than the fetched backlog, and pulses fetch on an empty ring; a loose design would move the completion index or let pending underflow. It crosses the index wrap to catch a phase that never steps, and issues unprivileged writes to each protected offset, where a leaky filter would change a base or the tail.

// File: rtl/ringdb_pkg.sv
package ringdb_pkg;

  localparam logic [7:0] OFF_BASE_LO  = 8'h00;
  localparam logic [7:0] OFF_BASE_HI  = 8'h04;
  localparam logic [7:0] OFF_CBASE_LO = 8'h08;
  localparam logic [7:0] OFF_CBASE_HI = 8'h0C;
  localparam logic [7:0] OFF_TAIL     = 8'h10;
  localparam logic [7:0] OFF_FETCH    = 8'h14;
  localparam logic [7:0] OFF_FREE     = 8'h18;
  localparam logic [7:0] OFF_PEND     = 8'h1C;
  localparam logic [7:0] OFF_STATUS   = 8'h20;
  localparam logic [7:0] OFF_CIDX     = 8'h34;
  localparam logic [7:0] OFF_DOORBELL = 8'h38;

  localparam int ST_OVF   = 0;
  localparam int ST_ACK   = 1;
  localparam int ST_ORDER = 2;
  localparam int ST_BLOCK = 3;
  localparam int ST_W     = 4;

  // One of the four base address words of a ring
  function automatic logic is_base(input logic [7:0] off);
    return (off[7:4] == 4'h0) && (off[1:0] == 2'b00);
  endfunction

  // Offsets that only privileged writers may change
  function automatic logic is_guarded(input logic [7:0] off);
    return is_base(off) || (off == OFF_DOORBELL);
  endfunction

endpackage

// File: rtl/ringdb_guard.sv
module ringdb_guard
  import ringdb_pkg::*;
(
  input  logic       wr,
  input  logic       priv,
  input  logic [7:0] off,
  output logic       wr_pass,
  output logic       wr_blocked
);

  logic guarded;

  assign guarded    = is_guarded(off);
  assign wr_blocked = wr && !priv && guarded;
  assign wr_pass    = wr && !wr_blocked;

endmodule

// File: rtl/ringdb_bank.sv
module ringdb_bank #(
  parameter  int DEPTH     = 4096,
  parameter  int GUARD     = 16,
  parameter  int MAX_BATCH = 2032,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int CNT_W     = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      db_val,
  input  logic             db_go,
  input  logic [15:0]      ack_exp,
  input  logic [15:0]      ack_cnt,
  input  logic             ack_go,
  input  logic             fetch,
  output logic             db_fit,
  output logic             ack_fit,
  output logic [IDX_W-1:0] tail,
  output logic [1:0]       tail_ph,
  output logic [IDX_W-1:0] cidx,
  output logic [1:0]       cidx_ph,
  output logic [IDX_W-1:0] fetch_idx,
  output logic [CNT_W-1:0] free,
  output logic [CNT_W-1:0] pend
);

  localparam int CAP = DEPTH - GUARD;

  // Advance an index by n; the phase steps once when the sum passes the top.
  function automatic logic [IDX_W+1:0] step(input logic [IDX_W-1:0] idx,
                                            input logic [1:0]       ph,
                                            input logic [CNT_W-1:0] n);
    logic [IDX_W:0] s;
    s = {1'b0, idx} + n;
    return {(s[IDX_W] ? ph + 2'd1 : ph), s[IDX_W-1:0]};
  endfunction

  logic [IDX_W-1:0] out_i;
  logic [IDX_W-1:0] done_i;
  logic [IDX_W-1:0] pend_i;

  assign out_i  = tail - cidx;
  assign done_i = fetch_idx - cidx;
  assign pend_i = tail - fetch_idx;

  assign free = CNT_W'(CAP) - {1'b0, out_i};
  assign pend = {1'b0, pend_i};

  assign db_fit  = (db_val <= 32'(free)) && (db_val <= 32'(MAX_BATCH));
  assign ack_fit = (32'(ack_exp) == 32'(cidx)) && (32'(ack_cnt) <= 32'(done_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail      <= '0;
      tail_ph   <= '0;
      cidx      <= '0;
      cidx_ph   <= '0;
      fetch_idx <= '0;
    end else begin
      if (db_go)
        {tail_ph, tail} <= step(tail, tail_ph, db_val[CNT_W-1:0]);
      if (ack_go)
        {cidx_ph, cidx} <= step(cidx, cidx_ph, CNT_W'(ack_cnt));
      if (fetch && (pend_i != '0))
        fetch_idx <= fetch_idx + 1'b1;
    end
  end

endmodule

// File: rtl/ringdb_unit.sv
module ringdb_unit
  import ringdb_pkg::*;
#(
  parameter  int DEPTH     = 4096,
  parameter  int GUARD     = 16,
  parameter  int MAX_BATCH = 2032,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int CNT_W     = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_priv,
  input  logic [8:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_fail,
  input  logic             rx_fetch,
  input  logic             tx_fetch,
  output logic [CNT_W-1:0] rx_pending,
  output logic [CNT_W-1:0] tx_pending
);

  logic       ring_sel;
  logic [7:0] off;
  assign ring_sel = bus_addr[8];
  assign off      = bus_addr[7:0];

  logic wr_pass, wr_blocked;

  ringdb_guard u_guard (
    .wr        (bus_wr),
    .priv      (bus_priv),
    .off       (off),
    .wr_pass   (wr_pass),
    .wr_blocked(wr_blocked)
  );

  logic sel_db, sel_ack, sel_stat;
  assign sel_db   = wr_pass && (off == OFF_DOORBELL);
  assign sel_ack  = wr_pass && (off == OFF_CIDX);
  assign sel_stat = wr_pass && (off == OFF_STATUS);

  // Receive-over-transmit leads for doorbells and acknowledges
  logic [31:0] db_lead, ack_lead;
  logic        db_order_ok, ack_order_ok;
  assign db_order_ok  = !ring_sel || (bus_wdata <= db_lead);
  assign ack_order_ok = !ring_sel || (32'(bus_wdata[31:16]) <= ack_lead);

  logic [1:0] db_fit, ack_fit, db_go, ack_go, fetch_v;
  logic       db_ok, ack_ok;
  assign fetch_v = {tx_fetch, rx_fetch};
  assign db_ok   = db_fit[ring_sel] && db_order_ok;
  assign ack_ok  = ack_fit[ring_sel] && ack_order_ok;

  logic [IDX_W-1:0] tail_a  [2];
  logic [1:0]       tph_a   [2];
  logic [IDX_W-1:0] cidx_a  [2];
  logic [1:0]       cph_a   [2];
  logic [IDX_W-1:0] fetch_a [2];
  logic [CNT_W-1:0] free_a  [2];
  logic [CNT_W-1:0] pend_a  [2];
  logic [ST_W-1:0]  st_a    [2];
  logic [31:0]      base_a  [2][4];

  for (genvar g = 0; g < 2; g++) begin : g_ring
    logic            hit;
    logic [ST_W-1:0] st_set;

    assign hit       = (ring_sel == 1'(g));
    assign db_go[g]  = sel_db && hit && db_ok;
    assign ack_go[g] = sel_ack && hit && ack_ok;

    ringdb_bank #(
      .DEPTH    (DEPTH),
      .GUARD    (GUARD),
      .MAX_BATCH(MAX_BATCH)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .db_val   (bus_wdata),
      .db_go    (db_go[g]),
      .ack_exp  (bus_wdata[15:0]),
      .ack_cnt  (bus_wdata[31:16]),
      .ack_go   (ack_go[g]),
      .fetch    (fetch_v[g]),
      .db_fit   (db_fit[g]),
      .ack_fit  (ack_fit[g]),
      .tail     (tail_a[g]),
      .tail_ph  (tph_a[g]),
      .cidx     (cidx_a[g]),
      .cidx_ph  (cph_a[g]),
      .fetch_idx(fetch_a[g]),
      .free     (free_a[g]),
      .pend     (pend_a[g])
    );

    assign st_set[ST_OVF]   = sel_db && hit && !db_fit[g];
    assign st_set[ST_ACK]   = sel_ack && hit && !ack_fit[g];
    assign st_set[ST_ORDER] = hit && ((sel_db && !db_order_ok) || (sel_ack && !ack_order_ok));
    assign st_set[ST_BLOCK] = wr_blocked && hit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_a[g] <= '0;
        for (int k = 0; k < 4; k++) base_a[g][k] <= '0;
      end else begin
        if (sel_stat && hit)
          st_a[g] <= st_a[g] & ~bus_wdata[ST_W-1:0];
        else
          st_a[g] <= st_a[g] | st_set;
        if (wr_pass && hit && is_base(off))
          base_a[g][off[3:2]] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_lead  <= '0;
      ack_lead <= '0;
    end else begin
      if (db_go[0]) db_lead <= db_lead + bus_wdata;
      if (db_go[1]) db_lead <= db_lead - bus_wdata;
      if (ack_go[0]) ack_lead <= ack_lead + 32'(bus_wdata[31:16]);
      if (ack_go[1]) ack_lead <= ack_lead - 32'(bus_wdata[31:16]);
    end
  end

  assign bus_fail = wr_blocked || (sel_db && !db_ok) || (sel_ack && !ack_ok);

  always_comb begin
    bus_rdata = '0;
    if (is_base(off)) begin
      bus_rdata = base_a[ring_sel][off[3:2]];
    end else begin
      case (off)
        OFF_TAIL:   bus_rdata = 32'({tph_a[ring_sel], 16'(tail_a[ring_sel])});
        OFF_FETCH:  bus_rdata = 32'(fetch_a[ring_sel]);
        OFF_FREE:   bus_rdata = 32'(free_a[ring_sel]);
        OFF_PEND:   bus_rdata = 32'(pend_a[ring_sel]);
        OFF_STATUS: bus_rdata = 32'(st_a[ring_sel]);
        OFF_CIDX:   bus_rdata = 32'({cph_a[ring_sel], 16'(cidx_a[ring_sel])});
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign rx_pending = pend_a[0];
  assign tx_pending = pend_a[1];

  // Named views for the bound checker
  logic [IDX_W-1:0] rx_tail, rx_cidx, rx_fetch_idx;
  logic [1:0]       rx_tail_ph;
  logic [CNT_W-1:0] rx_free, tx_free;
  logic [255:0]     base_flat;
  assign rx_tail      = tail_a[0];
  assign rx_tail_ph   = tph_a[0];
  assign rx_cidx      = cidx_a[0];
  assign rx_fetch_idx = fetch_a[0];
  assign rx_free      = free_a[0];
  assign tx_free      = free_a[1];
  assign base_flat    = {base_a[1][3], base_a[1][2], base_a[1][1], base_a[1][0],
                         base_a[0][3], base_a[0][2], base_a[0][1], base_a[0][0]};

endmodule

// File: rtl/ringdb_chk.sv
module ringdb_chk
  import ringdb_pkg::*;
#(
  parameter  int DEPTH = 4096,
  parameter  int GUARD = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_priv,
  input logic [8:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             bus_fail,
  input logic             wr_blocked,
  input logic [255:0]     base_flat,
  input logic [IDX_W-1:0] rx_tail,
  input logic [1:0]       rx_tail_ph,
  input logic [IDX_W-1:0] rx_cidx,
  input logic [IDX_W-1:0] rx_fetch_idx,
  input logic [CNT_W-1:0] rx_free,
  input logic [CNT_W-1:0] tx_free
);

  logic [IDX_W-1:0] rx_done, rx_out;
  assign rx_done = rx_fetch_idx - rx_cidx;
  assign rx_out  = rx_tail - rx_cidx;

  // R9
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_priv && is_guarded(bus_addr[7:0])) |-> bus_fail);

  // R9
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> $stable(base_flat));

  // R5
  free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_free <= CNT_W'(DEPTH - GUARD)) && (tx_free <= CNT_W'(DEPTH - GUARD)));

  // R3
  tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == 9'h038) && bus_fail) |=> $stable(rx_tail));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tail < $past(rx_tail)) |-> (rx_tail_ph == $past(rx_tail_ph) + 2'd1));

  // R7
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == 9'h034) && (32'(bus_wdata[15:0]) != 32'(rx_cidx)))
      |=> $stable(rx_cidx));

  // R7
  ack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done <= rx_out);

endmodule

bind ringdb_unit ringdb_chk #(.DEPTH(DEPTH), .GUARD(GUARD)) u_ringdb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_priv    (bus_priv),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_fail    (bus_fail),
  .wr_blocked  (wr_blocked),
  .base_flat   (base_flat),
  .rx_tail     (rx_tail),
  .rx_tail_ph  (rx_tail_ph),
  .rx_cidx     (rx_cidx),
  .rx_fetch_idx(rx_fetch_idx),
  .rx_free     (rx_free),
  .tx_free     (tx_free)
);

// File: tb/test_ringdb_unit.sv
module test_ringdb_unit;

  localparam int DEP  = 64;
  localparam int GRD  = 16;
  localparam int MAXB = 20;
  localparam int MSK  = DEP - 1;
  localparam int CW   = 7;

  logic          clk = 0, rst_n = 0;
  logic          bus_wr = 0, bus_priv = 0, rx_fetch = 0, tx_fetch = 0;
  logic [8:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_fail;
  logic [CW-1:0] rx_pending, tx_pending;

  ringdb_unit #(.DEPTH(DEP), .GUARD(GRD), .MAX_BATCH(MAXB)) i_ringdb_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_priv(bus_priv),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_fail(bus_fail), .rx_fetch(rx_fetch), .tx_fetch(tx_fetch),
    .rx_pending(rx_pending), .tx_pending(tx_pending)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int m_tail[2], m_tph[2], m_cidx[2], m_cph[2], m_fetch[2], m_st[2];
  int dlead = 0, alead = 0;
  logic [31:0] m_base[2][4];

  function automatic int mfree(int r); return DEP - GRD - ((m_tail[r] - m_cidx[r]) & MSK); endfunction
  function automatic int mpend(int r); return (m_tail[r] - m_fetch[r]) & MSK; endfunction
  function automatic int mdone(int r); return (m_fetch[r] - m_cidx[r]) & MSK; endfunction
  function automatic logic [8:0] ra(int r, logic [7:0] o); return {r[0], o}; endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic adv(inout int idx, inout int ph, input int n);
    idx += n;
    if (idx >= DEP) begin idx -= DEP; ph = (ph + 1) & 3; end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d, bit p, bit ef, string req);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_priv = p; bus_wr = 1;
    #1 chk(bus_fail == ef, req, 32'(bus_fail), 32'(ef));
    @(negedge clk);
    bus_wr = 0; bus_priv = 0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic do_db(int r, int n, bit p, string req);
    bit fit, ord, ef;
    if (!p) begin ef = 1; m_st[r] |= 8; end
    else begin
      fit = (n <= mfree(r)) && (n <= MAXB);
      ord = (r == 0) || (n <= dlead);
      ef  = !(fit && ord);
      if (!fit) m_st[r] |= 1;
      if (!ord) m_st[r] |= 4;
    end
    wr(ra(r, 8'h38), n, p, ef, req);
    if (!ef) begin
      adv(m_tail[r], m_tph[r], n);
      dlead += (r == 0) ? n : -n;
    end
  endtask

  task automatic do_ack(int r, int e, int c, bit p, string req);
    bit cas, ord, ef;
    cas = (e == m_cidx[r]) && (c <= mdone(r));
    ord = (r == 0) || (c <= alead);
    ef  = !(cas && ord);
    if (!cas) m_st[r] |= 2;
    if (!ord) m_st[r] |= 4;
    wr(ra(r, 8'h34), {c[15:0], e[15:0]}, p, ef, req);
    if (!ef) begin
      adv(m_cidx[r], m_cph[r], c);
      alead += (r == 0) ? c : -c;
    end
  endtask

  task automatic do_fetch(int r);
    @(negedge clk);
    if (r == 0) rx_fetch = 1; else tx_fetch = 1;
    @(negedge clk);
    rx_fetch = 0; tx_fetch = 0;
    if (mpend(r) > 0) m_fetch[r] = (m_fetch[r] + 1) % DEP;
  endtask

  task automatic verify(int r, string pre);
    logic [31:0] v;
    rd(ra(r, 8'h10), v); chk(v == 32'((m_tph[r] << 16) | m_tail[r]), {pre, " R2 tail"}, v, 32'((m_tph[r] << 16) | m_tail[r]));
    rd(ra(r, 8'h34), v); chk(v == 32'((m_cph[r] << 16) | m_cidx[r]), {pre, " R7 cidx"}, v, 32'((m_cph[r] << 16) | m_cidx[r]));
    rd(ra(r, 8'h18), v); chk(v == 32'(mfree(r)), {pre, " R5 free"}, v, 32'(mfree(r)));
    rd(ra(r, 8'h1C), v); chk(v == 32'(mpend(r)), {pre, " R6 pend"}, v, 32'(mpend(r)));
    rd(ra(r, 8'h14), v); chk(v == 32'(m_fetch[r]), {pre, " R6 fetch"}, v, 32'(m_fetch[r]));
    rd(ra(r, 8'h20), v); chk(v == 32'(m_st[r]), {pre, " R10 status"}, v, 32'(m_st[r]));
    v = 32'((r == 0) ? rx_pending : tx_pending);
    chk(v == 32'(mpend(r)), {pre, " R6 pending port"}, v, 32'(mpend(r)));
  endtask

  task automatic do_clr(int r, int m, bit p);
    wr(ra(r, 8'h20), 32'(m), p, 0, "R10 clear");
    m_st[r] &= ~m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned sd;
    sd = $urandom(32'd2024);
    for (int r = 0; r < 2; r++) begin
      m_tail[r] = 0; m_tph[r] = 0; m_cidx[r] = 0; m_cph[r] = 0; m_fetch[r] = 0; m_st[r] = 0;
      for (int k = 0; k < 4; k++) m_base[r][k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int r = 0; r < 2; r++) begin
      verify(r, "R1");
      for (int k = 0; k < 4; k++) begin
        rd(ra(r, 8'(k * 4)), v); chk(v == 0, "R1 base", v, 0);
      end
    end

    // R9 privileged base writes stick, unprivileged ones are blocked
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 4; k++) begin
        m_base[r][k] = 32'hA000_0000 + 32'(r * 16 + k);
        wr(ra(r, 8'(k * 4)), m_base[r][k], 1, 0, "R9 priv base");
      end
    wr(ra(1, 8'h04), 32'hDEAD_BEEF, 0, 1, "R9 unpriv base");
    m_st[1] |= 8;
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 4; k++) begin
        rd(ra(r, 8'(k * 4)), v); chk(v == m_base[r][k], "R9 base readback", v, m_base[r][k]);
      end
    do_db(0, 5, 0, "R9 unpriv doorbell");
    verify(0, "R9");
    do_clr(1, 8, 0);
    do_clr(0, 8, 0);
    verify(1, "R10");

    // R11 read-only writes ignored, doorbell reads zero
    wr(ra(0, 8'h10), 32'h7, 1, 0, "R11 ro write");
    rd(ra(0, 8'h38), v); chk(v == 0, "R11 doorbell read", v, 0);
    rd(ra(0, 8'h40), v); chk(v == 0, "R11 unmapped read", v, 0);
    verify(0, "R11");

    // R4 transmit before receive, R3 batch and capacity limits
    do_db(1, 5, 1, "R4 tx first");
    do_db(0, 21, 1, "R3 batch");
    do_db(0, 20, 1, "R2 rx db");
    do_db(1, 20, 1, "R4 tx db");
    do_db(0, 20, 1, "R2 rx db");
    do_db(0, 9, 1, "R3 over free");
    do_db(0, 8, 1, "R3 exact fill");
    verify(0, "R3"); verify(1, "R4");
    do_db(0, 1, 1, "R3 full");
    do_db(0, 0, 1, "R2 zero");
    verify(0, "R3");

    // R6 fetch drains pending, extra fetch ignored
    for (int i = 0; i < 21; i++) do_fetch(1);
    verify(1, "R6");
    // R7 stale index, count beyond fetched; R8 tx ack ahead of rx
    do_ack(0, 5, 0, 1, "R7 stale");
    do_ack(0, 0, 1, 0, "R7 over done");
    for (int i = 0; i < 48; i++) do_fetch(0);
    do_ack(1, 0, 5, 1, "R8 tx first");
    do_ack(0, 0, 48, 0, "R7 rx ack");
    do_ack(1, 0, 20, 1, "R8 tx ack");
    verify(0, "R7"); verify(1, "R8");
    do_clr(0, 15, 1); do_clr(1, 15, 0);

    // R2 wrap and phase step
    do_db(0, 20, 1, "R2 wrap");
    rd(ra(0, 8'h10), v); chk(v == 32'h0001_0004, "R2 wrap phase", v, 32'h0001_0004);
    verify(0, "R2");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int r, k;
      r = $urandom % 2;
      k = $urandom % 10;
      if (k < 4) do_db(r, $urandom % 24, ($urandom % 8) != 0, "R2/R3/R4 rnd");
      else if (k < 7) begin
        int n;
        n = $urandom % 6;
        for (int j = 0; j < n; j++) do_fetch(r);
      end else if (k < 9) begin
        int e, c;
        e = (($urandom % 4) == 0) ? int'($urandom % DEP) : m_cidx[r];
        c = int'($urandom % (mdone(r) + 3));
        do_ack(r, e, c, $urandom % 2, "R7/R8 rnd");
      end else do_clr(r, $urandom % 16, $urandom % 2);
      verify(r, "rnd");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule